// File: doc/BRIEF.md
# Smoke Alarm Horn Pattern Sequencer

This block turns a slow timing tick of about 10.4 ms into the single enable that keys a smoke alarm sounder. It produces every audible pattern the detector needs. During an alarm it plays either a three-pulse evacuation cadence or a fast repeating cadence. When the test button is held with alarm memory set, it chirps on a short period. Otherwise it plays supervisory chirps once per 43 s frame: a single chirp for a weak battery, and a single or triple chirp for a chamber or end-of-life problem. The two supervisory streams sit in separate slots of the frame, about 20 s apart, so a listener can tell them apart.

The conditions come in as plain level inputs from the detector's control logic. The block decides which one is heard, in strict priority order: alarm first, then the test chirp, then the supervisory chirps. All durations are counted in ticks and set by parameters. The defaults give 48/48/144 ticks for the temporal cadence, 24/8 for the continuous cadence, a frame of 4135 ticks, a fault slot offset of 1923 ticks, a triple spacing of 32 ticks and a test chirp period of 24 ticks. The parameters must satisfy OFFSET + 2·GAP < FRAME, OFFSET > 0 and PTT_PERIOD ≥ 2.

Top module: `horn_pattern_sequencer`

## Requirements
- R1: While rst_n is low, and after its release with no condition active, horn_on is 0. The frame position resets to 0 and advances by one on each clock edge where tick is 1.
- R2: With tone_temporal = 1, an alarm sounds TEMP_ON ticks on, TEMP_OFF off, TEMP_ON on, TEMP_OFF off, TEMP_ON on, then TEMP_LONG_OFF off, and repeats.
- R3: With tone_temporal = 0, an alarm sounds CONT_ON ticks on and then CONT_OFF ticks off, and repeats.
- R4: An alarm always starts its cadence with the first on-pulse, in the same cycle that alarm_active rises, even after an alarm that ended part-way through.
- R5: A battery fault alone sounds a one-tick chirp at frame position 0 of every frame.
- R6: While lowbat_silence is 1, the battery chirp is suppressed. The other fault chirps are not affected.
- R7: chamber_fault alone sounds a one-tick chirp at frame position OFFSET.
- R8: chamber_repeat_fault or end_of_life sounds three one-tick chirps at positions OFFSET, OFFSET+GAP and OFFSET+2·GAP. This triple form takes precedence over the single chamber chirp.
- R9: When a battery fault and a chamber fault are both present, both chirps sound in their own slots, OFFSET ticks apart.
- R10: While ptt_memory is 1, a one-tick chirp sounds at once and then every PTT_PERIOD ticks.
- R11: Priority is alarm, then test chirp, then supervisory chirps. A lower-priority condition is silent whenever a higher one is active, including during the alarm's off phases.
- R12: Clock edges with tick = 0 advance no cadence, frame or test counter, so horn_on holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe, about 10.4 ms apart |
| alarm_active | input | 1 | Local or remote alarm in progress |
| tone_temporal | input | 1 | 1 selects the three-pulse cadence, 0 the continuous cadence |
| lowbat_fault | input | 1 | Battery below trip point |
| chamber_fault | input | 1 | Latest chamber test failed |
| chamber_repeat_fault | input | 1 | Two consecutive chamber tests failed |
| end_of_life | input | 1 | Unit has reached its replacement age |
| ptt_memory | input | 1 | Test button held while alarm memory is set |
| lowbat_silence | input | 1 | Battery chirp silence window is open |
| horn_on | output | 1 | Sounder enable |

## Verification
The bench checks the boundaries of the three-pulse cadence: the third on-pulse, and where the long off gap ends and the cycle wraps. A counter with the wrong cycle length would drift out of phase there. It raises an alarm again after dropping it part-way through a cadence, which exposes a counter that resumes instead of restarting. It also checks the exact frame slots of single and triple chirps, alone and together. A slot decode that is off by one, or that lets the single form override the triple form, is caught there. It checks that silence mutes only the battery chirp, and that alarm off phases stay quiet while other conditions are pending. Finally it holds tick low across an on/off boundary, which exposes counters that advance on every clock.

// File: rtl/horn_pkg.sv
package horn_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'd0,
    FAULT_SINGLE = 2'd1,
    FAULT_TRIPLE = 2'd2
  } fault_mode_e;

  // Triple form wins over the single chamber chirp.
  function automatic fault_mode_e pick_fault(input logic repeat_fail,
                                             input logic aged,
                                             input logic single_fail);
    if (repeat_fail || aged) return FAULT_TRIPLE;
    else if (single_fail)    return FAULT_SINGLE;
    else                     return FAULT_NONE;
  endfunction

endpackage

// File: rtl/horn_alarm_pattern.sv
module horn_alarm_pattern #(
  parameter int TEMP_ON       = 48,
  parameter int TEMP_OFF      = 48,
  parameter int TEMP_LONG_OFF = 144,
  parameter int CONT_ON       = 24,
  parameter int CONT_OFF      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic temporal,
  output logic horn
);
  localparam int LT   = 3*TEMP_ON + 2*TEMP_OFF + TEMP_LONG_OFF;
  localparam int LC   = CONT_ON + CONT_OFF;
  localparam int LMAX = (LT > LC) ? LT : LC;
  localparam int AW   = $clog2(LMAX + 1);

  logic [AW-1:0] pos;
  logic [AW-1:0] last;
  logic          t_on, c_on;

  assign last = temporal ? AW'(LT - 1) : AW'(LC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (!active) pos <= '0;
    else if (tick)    pos <= (pos >= last) ? '0 : pos + AW'(1);
  end

  always_comb begin
    t_on = (pos < AW'(TEMP_ON)) ||
           ((pos >= AW'(TEMP_ON + TEMP_OFF)) && (pos < AW'(2*TEMP_ON + TEMP_OFF))) ||
           ((pos >= AW'(2*TEMP_ON + 2*TEMP_OFF)) && (pos < AW'(3*TEMP_ON + 2*TEMP_OFF)));
    c_on = (pos < AW'(CONT_ON));
    horn = active && (temporal ? t_on : c_on);
  end

  // R4: a fresh alarm opens with sound
  p_restart_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> horn);

  // R2/R3: the position never leaves the longest cadence
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < AW'(LMAX));

endmodule

// File: rtl/horn_frame_timer.sv
module horn_frame_timer
  import horn_pkg::*;
#(
  parameter int FRAME  = 4135,
  parameter int OFFSET = 1923,
  parameter int GAP    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lowbat_req,
  input  fault_mode_e fault_mode,
  output logic        chirp
);
  localparam int FW = $clog2(FRAME);

  logic [FW-1:0] fpos;
  logic          slot_lb, slot_f0, slot_f1, slot_f2;

  always_ff @(posedge clk) begin
    if (!rst_n)    fpos <= '0;
    else if (tick) fpos <= (fpos == FW'(FRAME - 1)) ? '0 : fpos + FW'(1);
  end

  always_comb begin
    slot_lb = (fpos == '0);
    slot_f0 = (fpos == FW'(OFFSET));
    slot_f1 = (fpos == FW'(OFFSET + GAP));
    slot_f2 = (fpos == FW'(OFFSET + 2*GAP));
    chirp   = lowbat_req && slot_lb;
    unique case (fault_mode)
      FAULT_SINGLE: chirp = chirp || slot_f0;
      FAULT_TRIPLE: chirp = chirp || slot_f0 || slot_f1 || slot_f2;
      default:      ;
    endcase
  end

  // R1/R5: frame wraps to zero after its last tick
  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fpos == FW'(FRAME - 1)) |=> (fpos == '0));

  // R12: no tick, no movement
  p_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fpos));

endmodule

// File: rtl/horn_ptt_chirp.sv
module horn_ptt_chirp #(
  parameter int PTT_PERIOD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic chirp
);
  localparam int PW = $clog2(PTT_PERIOD);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (tick)    cnt <= (cnt == PW'(PTT_PERIOD - 1)) ? '0 : cnt + PW'(1);
  end

  assign chirp = active && (cnt == '0);

  // R10: each test chirp lasts exactly one tick
  p_chirp_one_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp && tick) |=> !chirp);

endmodule

// File: rtl/horn_pattern_sequencer.sv
module horn_pattern_sequencer
  import horn_pkg::*;
#(
  parameter int TEMP_ON       = 48,
  parameter int TEMP_OFF      = 48,
  parameter int TEMP_LONG_OFF = 144,
  parameter int CONT_ON       = 24,
  parameter int CONT_OFF      = 8,
  parameter int FRAME         = 4135,
  parameter int OFFSET        = 1923,
  parameter int GAP           = 32,
  parameter int PTT_PERIOD    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic alarm_active,
  input  logic tone_temporal,
  input  logic lowbat_fault,
  input  logic chamber_fault,
  input  logic chamber_repeat_fault,
  input  logic end_of_life,
  input  logic ptt_memory,
  input  logic lowbat_silence,
  output logic horn_on
);
  logic        alarm_horn, ptt_horn, sup_horn;
  fault_mode_e fault_mode;

  assign fault_mode = pick_fault(chamber_repeat_fault, end_of_life, chamber_fault);

  horn_alarm_pattern #(
    .TEMP_ON(TEMP_ON), .TEMP_OFF(TEMP_OFF), .TEMP_LONG_OFF(TEMP_LONG_OFF),
    .CONT_ON(CONT_ON), .CONT_OFF(CONT_OFF)
  ) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(alarm_active), .temporal(tone_temporal), .horn(alarm_horn)
  );

  horn_ptt_chirp #(.PTT_PERIOD(PTT_PERIOD)) u_ptt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(ptt_memory), .chirp(ptt_horn)
  );

  horn_frame_timer #(.FRAME(FRAME), .OFFSET(OFFSET), .GAP(GAP)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lowbat_req(lowbat_fault && !lowbat_silence),
    .fault_mode(fault_mode), .chirp(sup_horn)
  );

  always_comb begin
    if (alarm_active)    horn_on = alarm_horn;
    else if (ptt_memory) horn_on = ptt_horn;
    else                 horn_on = sup_horn;
  end

  // R11: alarm off phases stay quiet whatever else is pending
  p_alarm_gap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_active && !alarm_horn) |-> !horn_on);

  // R6: a silenced battery fault alone makes no sound
  p_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lowbat_silence && !alarm_active && !ptt_memory && !chamber_fault &&
     !chamber_repeat_fault && !end_of_life) |-> !horn_on);

  // R1: nothing requested, nothing sounds
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_active && !ptt_memory && !lowbat_fault && !chamber_fault &&
     !chamber_repeat_fault && !end_of_life) |-> !horn_on);

endmodule

// File: tb/tb_horn_pattern_sequencer.sv
module tb_horn_pattern_sequencer;
  localparam int T_ON = 3, T_OFF = 2, T_LONG = 6;
  localparam int C_ON = 4, C_OFF = 2;
  localparam int FR = 40, OFS = 15, GP = 4, PP = 5;
  localparam int LT = 3*T_ON + 2*T_OFF + T_LONG;
  localparam int LC = C_ON + C_OFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic alarm_active = 1'b0, tone_temporal = 1'b0, lowbat_fault = 1'b0;
  logic chamber_fault = 1'b0, chamber_repeat_fault = 1'b0, end_of_life = 1'b0;
  logic ptt_memory = 1'b0, lowbat_silence = 1'b0;
  logic horn_on;

  int n_chk = 0, n_bad = 0;
  int nticks = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n && tick) nticks <= nticks + 1;

  horn_pattern_sequencer #(
    .TEMP_ON(T_ON), .TEMP_OFF(T_OFF), .TEMP_LONG_OFF(T_LONG),
    .CONT_ON(C_ON), .CONT_OFF(C_OFF), .FRAME(FR), .OFFSET(OFS),
    .GAP(GP), .PTT_PERIOD(PP)
  ) dut (.*);

  task automatic chk(input logic exp, input string req, input int at);
    n_chk++;
    if (horn_on !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: horn_on=%b expected %b", req, at, horn_on, exp);
    end
  endtask

  function automatic logic temporal_on(input int p);
    return (p < T_ON) || (p >= T_ON + T_OFF && p < 2*T_ON + T_OFF) ||
           (p >= 2*T_ON + 2*T_OFF && p < 3*T_ON + 2*T_OFF);
  endfunction

  function automatic logic sup_exp(input int p, input logic lb, input logic sil,
                                   input logic ch, input logic trip);
    logic e;
    e = lb && !sil && (p == 0);
    if (trip)    e = e || p == OFS || p == OFS + GP || p == OFS + 2*GP;
    else if (ch) e = e || p == OFS;
    return e;
  endfunction

  task automatic clear_inputs();
    alarm_active = 0; tone_temporal = 0; lowbat_fault = 0; chamber_fault = 0;
    chamber_repeat_fault = 0; end_of_life = 0; ptt_memory = 0; lowbat_silence = 0;
  endtask

  // Runs n ticks, checking each against the supervisory frame expectation.
  task automatic run_frame(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      #1;
      chk(sup_exp(nticks % FR, lowbat_fault, lowbat_silence, chamber_fault,
                  chamber_repeat_fault || end_of_life), req, i);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1; chk(1'b0, "R1 in reset", 0);
    @(negedge clk); rst_n = 1; tick = 1;
    for (int i = 0; i < 6; i++) begin #1; chk(1'b0, "R1 idle", i); @(negedge clk); end
  endtask

  task automatic t_alarm(input logic temporal, input int cycles, input string req);
    clear_inputs(); tone_temporal = temporal; alarm_active = 1;
    for (int k = 0; k < cycles; k++) begin
      #1;
      chk(temporal ? temporal_on(k % LT) : (k % LC) < C_ON, req, k);
      @(negedge clk);
    end
    alarm_active = 0; @(negedge clk);
  endtask

  task automatic t_restart();
    clear_inputs(); tone_temporal = 1; alarm_active = 1;
    repeat (T_ON + 1) @(negedge clk);      // now in first off gap
    #1; chk(1'b0, "R4 mid gap", 0);
    alarm_active = 0; @(negedge clk);
    alarm_active = 1;
    for (int k = 0; k < LT; k++) begin #1; chk(temporal_on(k), "R4 restart", k); @(negedge clk); end
    alarm_active = 0; @(negedge clk);
  endtask

  task automatic t_lowbat();
    clear_inputs(); lowbat_fault = 1; run_frame(2*FR, "R5 battery chirp");
  endtask

  task automatic t_silence();
    clear_inputs(); lowbat_fault = 1; lowbat_silence = 1; run_frame(FR, "R6 silenced");
    chamber_fault = 1; run_frame(FR, "R6 chamber through silence");
  endtask

  task automatic t_chamber();
    clear_inputs(); chamber_fault = 1; run_frame(FR, "R7 single chamber");
  endtask

  task automatic t_triple();
    clear_inputs(); chamber_repeat_fault = 1; chamber_fault = 1; run_frame(FR, "R8 repeat fault");
    clear_inputs(); end_of_life = 1; run_frame(FR, "R8 end of life");
  endtask

  task automatic t_both();
    clear_inputs(); lowbat_fault = 1; chamber_fault = 1; run_frame(2*FR, "R9 two streams");
  endtask

  task automatic t_ptt();
    clear_inputs(); ptt_memory = 1;
    for (int k = 0; k < 3*PP; k++) begin #1; chk((k % PP) == 0, "R10 test chirp", k); @(negedge clk); end
    ptt_memory = 0; @(negedge clk);
  endtask

  task automatic t_priority();
    clear_inputs(); ptt_memory = 1; lowbat_fault = 1; chamber_repeat_fault = 1;
    for (int k = 0; k < 2*FR; k++) begin #1; chk((k % PP) == 0, "R11 test over supervisory", k); @(negedge clk); end
    ptt_memory = 0; @(negedge clk);
    alarm_active = 1; ptt_memory = 1; tone_temporal = 1;
    for (int k = 0; k < 2*FR; k++) begin #1; chk(temporal_on(k % LT), "R11 alarm over all", k); @(negedge clk); end
    clear_inputs(); @(negedge clk);
  endtask

  task automatic t_tick_hold();
    clear_inputs(); tone_temporal = 1; alarm_active = 1;
    repeat (T_ON - 1) @(negedge clk);      // last tick of first on-pulse
    tick = 0;
    for (int k = 0; k < 5; k++) begin #1; chk(1'b1, "R12 held by tick", k); @(negedge clk); end
    tick = 1;
    #1; chk(1'b1, "R12 resume", 0); @(negedge clk);
    #1; chk(1'b0, "R12 resume gap", 1); @(negedge clk);
    alarm_active = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_alarm(1'b1, 2*LT + 1, "R2 temporal");
    t_alarm(1'b0, 3*LC, "R3 continuous");
    t_restart();
    t_lowbat();
    t_silence();
    t_chamber();
    t_triple();
    t_both();
    t_ptt();
    t_priority();
    t_tick_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule